// File: doc/BRIEF.md
# Integer Branch and Conditional Move Resolver

This unit resolves integer control transfers and conditional register moves for one instruction per cycle. The issue stage presents a 32-bit instruction word, its program counter and the two register read values. The unit classifies the word and evaluates a condition on the first operand. It then reports, one clock later, whether fetch must be redirected, which address follows the instruction, and an optional register write-back. Conditional branches and conditional moves share one condition evaluator.

The unit handles conditional branches, the two linking unconditional branches and register-indirect jumps. Branch targets are the incremented PC plus a sign-extended 21-bit word displacement. Jump targets come from the second register with its two low bits cleared. Linking forms write the incremented PC to the register named in bits [25:21]. Conditional moves write operand B to the register named in bits [4:0] only when their condition holds. Operand B is either the second register value or an 8-bit literal taken from the word.

A small state machine records the kind of result held in the output registers. It has three states: `ST_IDLE` means no instruction was presented, `ST_REDIRECT` means the held result is a taken transfer, and `ST_FALLTHRU` means the held result continues sequentially. From any state, a valid taken instruction moves it to `ST_REDIRECT`, a valid untaken or non-transfer instruction moves it to `ST_FALLTHRU`, and a cycle with no valid instruction moves it to `ST_IDLE`. The state machine resets to `ST_IDLE`.

Top module: `bru_unit`

## Requirements
- R1: After reset, `redirect` and `wr_en` are low, and they stay low until an instruction is issued.
- R2: A conditional branch is identified by bits [31:26]. It is taken when the signed value of `ra_val` compares against zero as follows: 0x39 taken if equal to zero, 0x3D if not equal, 0x3A if less, 0x3E if greater or equal, 0x3B if less or equal, 0x3F if greater.
- R3: Opcode 0x38 is taken when bit 0 of `ra_val` is 0, and opcode 0x3C is taken when that bit is 1. No other bit of `ra_val` affects these two opcodes.
- R4: A taken branch sets `next_pc` to PC + 4 + (sign-extended bits [20:0] shifted left by 2). An untaken branch sets `next_pc` to PC + 4.
- R5: Opcodes 0x30 and 0x34 are always taken, use the R4 target, and write PC + 4 to the register named in bits [25:21].
- R6: Opcode 0x1A is always taken with `next_pc` = `rb_val` with bits [1:0] cleared, and writes PC + 4 to the register in bits [25:21]. The kind field in bits [15:14] (0, 1 or 2) does not change this behaviour.
- R7: Opcode 0x11 with function bits [11:5] equal to 0x24 (EQ), 0x26 (NE), 0x44 (LT), 0x46 (GE), 0x64 (LE), 0x66 (GT), 0x14 (low bit set) or 0x16 (low bit clear) is a conditional move. It writes operand B to the register in bits [4:0] when the condition on `ra_val` holds, keeps `wr_en` low when the condition fails, never redirects, and sets `next_pc` to PC + 4.
- R8: For a conditional move with bit 12 set, operand B is the zero-extended literal in bits [20:13]. With bit 12 clear, operand B is `rb_val`.
- R9: A write whose destination is register 31 is discarded: `wr_en` stays low, while `redirect` and `next_pc` behave normally.
- R10: Results appear in the cycle after `issue_valid`. `redirect` is high for one cycle per taken instruction, so back-to-back taken instructions give consecutive high cycles. A cycle without `issue_valid` gives `redirect` and `wr_en` low in the next cycle.
- R11: Any other opcode, or opcode 0x11 with an unlisted function, gives no redirect and no write, and `next_pc` is PC + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| ra_val | input | XLEN | Value of the register named in bits [25:21] |
| rb_val | input | XLEN | Value of the register named in bits [20:16] |
| redirect | output | 1 | Taken transfer; fetch must restart at `next_pc` |
| next_pc | output | XLEN | Address of the following instruction |
| wr_en | output | 1 | Register write-back valid |
| wr_addr | output | 5 | Write-back register number |
| wr_data | output | XLEN | Write-back value |

## Verification
The bench checks the sign boundary by using operands with only the top bit set. A design that compared unsigned values, or tested the wrong bit, would then take GT or LT branches the wrong way. Low-bit conditions are driven with even negative and odd positive values, so a design that fell back to a sign test gives the wrong outcome. Targets are checked with negative and largest positive displacements, which exposes missing sign extension or a target based on the PC before increment. Jumps use a misaligned `rb_val`, moves target register 31, and a literal-form move has a differing `rb_val`. These expose, in turn, a missing alignment mask, a write that leaks through, and the wrong operand source.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam logic [5:0] OP_BR   = 6'h30;
    localparam logic [5:0] OP_BSR  = 6'h34;
    localparam logic [5:0] OP_JUMP = 6'h1A;
    localparam logic [5:0] OP_CMOV = 6'h11;
    localparam logic [2:0] BCOND_HI = 3'b111;
    localparam logic [4:0] ZERO_REG = 5'd31;

    typedef enum logic [3:0] {
        CND_EQ, CND_NE, CND_LT, CND_GE, CND_LE, CND_GT,
        CND_LBC, CND_LBS, CND_ALWAYS
    } cond_e;

    typedef enum logic [2:0] {
        CLS_NONE, CLS_BCOND, CLS_BLINK, CLS_JUMP, CLS_CMOV
    } class_e;

    typedef struct packed {
        class_e     cls;
        cond_e      cnd;
        logic [4:0] dst;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE, ST_REDIRECT, ST_FALLTHRU
    } state_e;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec,
    output logic        lit_sel
);
    logic [5:0] opcode;
    logic [6:0] func;

    assign opcode  = instr[31:26];
    assign func    = instr[11:5];
    assign lit_sel = instr[12];

    always_comb begin
        dec = '{cls: CLS_NONE, cnd: CND_ALWAYS, dst: ZERO_REG};
        if (opcode == OP_BR || opcode == OP_BSR) begin
            dec = '{cls: CLS_BLINK, cnd: CND_ALWAYS, dst: instr[25:21]};
        end else if (opcode == OP_JUMP) begin
            dec = '{cls: CLS_JUMP, cnd: CND_ALWAYS, dst: instr[25:21]};
        end else if (opcode[5:3] == BCOND_HI) begin
            dec.cls = CLS_BCOND;
            unique case (opcode[2:0])
                3'd0: dec.cnd = CND_LBC;
                3'd1: dec.cnd = CND_EQ;
                3'd2: dec.cnd = CND_LT;
                3'd3: dec.cnd = CND_LE;
                3'd4: dec.cnd = CND_LBS;
                3'd5: dec.cnd = CND_NE;
                3'd6: dec.cnd = CND_GE;
                default: dec.cnd = CND_GT;
            endcase
        end else if (opcode == OP_CMOV) begin
            dec.dst = instr[4:0];
            dec.cls = CLS_CMOV;
            unique case (func)
                7'h24: dec.cnd = CND_EQ;
                7'h26: dec.cnd = CND_NE;
                7'h44: dec.cnd = CND_LT;
                7'h46: dec.cnd = CND_GE;
                7'h64: dec.cnd = CND_LE;
                7'h66: dec.cnd = CND_GT;
                7'h14: dec.cnd = CND_LBS;
                7'h16: dec.cnd = CND_LBC;
                default: begin
                    dec.cls = CLS_NONE;
                    dec.dst = ZERO_REG;
                end
            endcase
        end
    end
endmodule

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cond_e            cnd,
    input  logic [XLEN-1:0]  val,
    output logic             hold
);
    logic is_zero;
    logic is_neg;
    logic low_bit;

    assign is_zero = (val == '0);
    assign is_neg  = val[XLEN-1];
    assign low_bit = val[0];

    always_comb begin
        unique case (cnd)
            CND_EQ:  hold = is_zero;
            CND_NE:  hold = !is_zero;
            CND_LT:  hold = is_neg;
            CND_GE:  hold = !is_neg;
            CND_LE:  hold = is_neg || is_zero;
            CND_GT:  hold = !is_neg && !is_zero;
            CND_LBC: hold = !low_bit;
            CND_LBS: hold = low_bit;
            default: hold = 1'b1;
        endcase
    end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
    parameter int XLEN     = 64,
    parameter int DISP_W   = 21,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rb_val,
    input  logic            is_jump,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] tgt_pc
);
    localparam int EXT_W = XLEN - DISP_W - 2;

    logic [XLEN-1:0] disp_bytes;

    assign seq_pc     = pc + XLEN'(INSN_BYTES);
    assign disp_bytes = {{EXT_W{instr[DISP_W-1]}}, instr[DISP_W-1:0], 2'b00};
    assign tgt_pc     = is_jump ? {rb_val[XLEN-1:2], 2'b00} : seq_pc + disp_bytes;
endmodule

// File: rtl/bru_unit.sv
module bru_unit
    import bru_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] ra_val,
    input  logic [XLEN-1:0] rb_val,
    output logic            redirect,
    output logic [XLEN-1:0] next_pc,
    output logic            wr_en,
    output logic [4:0]      wr_addr,
    output logic [XLEN-1:0] wr_data
);
    localparam int LIT_W = 8;

    dec_t            dec;
    logic            lit_sel;
    logic            cond_hold;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] tgt_pc;
    logic [XLEN-1:0] opnd_b;
    logic            is_xfer;
    logic            is_link;
    logic            take;
    logic            move;
    logic            wr_nxt;
    state_e          state_q;
    state_e          state_d;

    bru_decode u_decode (
        .instr   (instr),
        .dec     (dec),
        .lit_sel (lit_sel)
    );

    bru_cond_eval #(.XLEN(XLEN)) u_cond (
        .cnd  (dec.cnd),
        .val  (ra_val),
        .hold (cond_hold)
    );

    bru_target #(.XLEN(XLEN)) u_target (
        .pc      (pc),
        .instr   (instr),
        .rb_val  (rb_val),
        .is_jump (dec.cls == CLS_JUMP),
        .seq_pc  (seq_pc),
        .tgt_pc  (tgt_pc)
    );

    assign is_link = (dec.cls == CLS_BLINK) || (dec.cls == CLS_JUMP);
    assign is_xfer = is_link || (dec.cls == CLS_BCOND);
    assign take    = issue_valid && is_xfer && cond_hold;
    assign move    = issue_valid && (dec.cls == CLS_CMOV) && cond_hold;
    assign opnd_b  = lit_sel ? {{(XLEN-LIT_W){1'b0}}, instr[20:13]} : rb_val;
    assign wr_nxt  = (move || (issue_valid && is_link)) && (dec.dst != ZERO_REG);

    always_comb begin
        unique case (1'b1)
            !issue_valid: state_d = ST_IDLE;
            take:         state_d = ST_REDIRECT;
            default:      state_d = ST_FALLTHRU;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_pc <= '0;
            wr_en   <= 1'b0;
            wr_addr <= ZERO_REG;
            wr_data <= '0;
        end else begin
            wr_en <= wr_nxt;
            if (issue_valid) begin
                next_pc <= take ? tgt_pc : seq_pc;
                wr_addr <= dec.dst;
                wr_data <= move ? opnd_b : seq_pc;
            end
        end
    end

    assign redirect = (state_q == ST_REDIRECT);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> (!redirect && !wr_en));

    assert_jump_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && instr[31:26] == OP_JUMP) |=> (redirect && next_pc[1:0] == 2'b00));

    assert_cmov_sequential_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && instr[31:26] == OP_CMOV) |=>
            (!redirect && next_pc == $past(pc) + XLEN'(4)));

    assert_zero_reg_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != ZERO_REG));

    assert_link_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && (instr[31:26] == OP_BR || instr[31:26] == OP_BSR)
            && instr[25:21] != ZERO_REG) |=>
            (redirect && wr_en && wr_data == $past(pc) + XLEN'(4)));
endmodule

// File: tb/bru_unit_tb.sv
`timescale 1ns/1ps
module bru_unit_tb;
    localparam int XLEN = 64;
    localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] TOPB = 64'h8000_0000_0000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] pc = '0;
    logic [XLEN-1:0] ra_val = '0;
    logic [XLEN-1:0] rb_val = '0;
    logic            redirect;
    logic [XLEN-1:0] next_pc;
    logic            wr_en;
    logic [4:0]      wr_addr;
    logic [XLEN-1:0] wr_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bru_unit #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .pc(pc), .ra_val(ra_val), .rb_val(rb_val), .redirect(redirect),
        .next_pc(next_pc), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] br_word(input logic [5:0] op, input logic [4:0] ra,
                                            input logic [20:0] disp);
        return {op, ra, disp};
    endfunction

    function automatic logic [31:0] jmp_word(input logic [4:0] ra, input logic [4:0] rb,
                                             input logic [1:0] kind);
        return {6'h1A, ra, rb, kind, 14'h0155};
    endfunction

    function automatic logic [31:0] cmov_word(input logic [6:0] fn, input logic [4:0] rc,
                                              input logic lit, input logic [7:0] litv);
        if (lit) return {6'h11, 5'd1, litv, 1'b1, fn, rc};
        return {6'h11, 5'd1, 5'd2, 3'b000, 1'b0, fn, rc};
    endfunction

    // Present one instruction; results are visible on return.
    task automatic issue(input logic [31:0] w, input logic [63:0] p,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        instr = w; pc = p; ra_val = a; rb_val = b; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 redirect after reset", {63'd0, redirect}, 64'd0);
        chk("R1 wr_en after reset", {63'd0, wr_en}, 64'd0);
        @(negedge clk);
        chk("R1 redirect while idle", {63'd0, redirect}, 64'd0);
    endtask

    task automatic br_case(input string tag, input logic [5:0] op, input logic [63:0] a,
                           input logic exp_t);
        issue(br_word(op, 5'd3, 21'd3), 64'h1000, a, 64'd0);
        chk(tag, {63'd0, redirect}, {63'd0, exp_t});
        chk({tag, " next_pc R4"}, next_pc, exp_t ? 64'h1010 : 64'h1004);
        chk({tag, " no write"}, {63'd0, wr_en}, 64'd0);
    endtask

    task automatic t_signed_branches();
        br_case("R2 EQ zero", 6'h39, 64'd0, 1'b1);
        br_case("R2 EQ one", 6'h39, 64'd1, 1'b0);
        br_case("R2 NE zero", 6'h3D, 64'd0, 1'b0);
        br_case("R2 NE neg", 6'h3D, NEG1, 1'b1);
        br_case("R2 LT neg", 6'h3A, NEG1, 1'b1);
        br_case("R2 LT zero", 6'h3A, 64'd0, 1'b0);
        br_case("R2 LT topbit", 6'h3A, TOPB, 1'b1);
        br_case("R2 GE zero", 6'h3E, 64'd0, 1'b1);
        br_case("R2 GE neg", 6'h3E, 64'hFFFF_FFFF_FFFF_FFFB, 1'b0);
        br_case("R2 LE zero", 6'h3B, 64'd0, 1'b1);
        br_case("R2 LE pos", 6'h3B, 64'd7, 1'b0);
        br_case("R2 GT pos", 6'h3F, 64'd7, 1'b1);
        br_case("R2 GT zero", 6'h3F, 64'd0, 1'b0);
        br_case("R2 GT topbit", 6'h3F, TOPB, 1'b0);
    endtask

    task automatic t_low_bit();
        br_case("R3 LBC even", 6'h38, 64'd2, 1'b1);
        br_case("R3 LBC odd", 6'h38, 64'd3, 1'b0);
        br_case("R3 LBC even negative", 6'h38, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1);
        br_case("R3 LBS odd", 6'h3C, 64'd3, 1'b1);
        br_case("R3 LBS topbit even", 6'h3C, TOPB, 1'b0);
    endtask

    task automatic t_targets();
        issue(br_word(6'h39, 5'd0, 21'h1FFFFC), 64'h1000, 64'd0, 64'd0);
        chk("R4 negative displacement", next_pc, 64'h0FF4);
        issue(br_word(6'h39, 5'd0, 21'h0FFFFF), 64'h1000, 64'd0, 64'd0);
        chk("R4 largest positive displacement", next_pc, 64'h1000 + 64'd4 + 64'h3FFFFC);
        issue(br_word(6'h39, 5'd0, 21'h100000), 64'h0100_0000, 64'd0, 64'd0);
        chk("R4 most negative displacement", next_pc, 64'h0100_0004 - 64'h40_0000);
    endtask

    task automatic t_uncond();
        issue(br_word(6'h30, 5'd26, 21'd5), 64'h2000, 64'd1, 64'd0);
        chk("R5 BR redirect", {63'd0, redirect}, 64'd1);
        chk("R5 BR target", next_pc, 64'h2018);
        chk("R5 BR wr_en", {63'd0, wr_en}, 64'd1);
        chk("R5 BR wr_addr", {59'd0, wr_addr}, 64'd26);
        chk("R5 BR link", wr_data, 64'h2004);
        issue(br_word(6'h34, 5'd31, 21'h1FFFFF), 64'h2000, 64'd0, 64'd0);
        chk("R9 BSR r31 redirect", {63'd0, redirect}, 64'd1);
        chk("R9 BSR r31 target", next_pc, 64'h2000);
        chk("R9 BSR r31 no write", {63'd0, wr_en}, 64'd0);
        issue(br_word(6'h34, 5'd9, 21'd0), 64'h3000, 64'd0, 64'd0);
        chk("R5 BSR link", wr_data, 64'h3004);
        chk("R5 BSR wr_addr", {59'd0, wr_addr}, 64'd9);
    endtask

    task automatic t_jump();
        for (int k = 0; k < 3; k++) begin
            issue(jmp_word(5'd26, 5'd4, 2'(k)), 64'h5000, 64'd0, 64'h0000_0000_0000_4007);
            chk($sformatf("R6 jump kind %0d redirect", k), {63'd0, redirect}, 64'd1);
            chk($sformatf("R6 jump kind %0d target", k), next_pc, 64'h4004);
            chk($sformatf("R6 jump kind %0d link", k), wr_data, 64'h5004);
            chk($sformatf("R6 jump kind %0d wr_en", k), {63'd0, wr_en}, 64'd1);
        end
    endtask

    task automatic cm_case(input string tag, input logic [6:0] fn, input logic [63:0] a,
                           input logic exp_m);
        issue(cmov_word(fn, 5'd7, 1'b0, 8'd0), 64'h6000, a, 64'hABCD);
        chk({tag, " wr_en"}, {63'd0, wr_en}, {63'd0, exp_m});
        chk({tag, " no redirect"}, {63'd0, redirect}, 64'd0);
        chk({tag, " next_pc"}, next_pc, 64'h6004);
        if (exp_m) begin
            chk({tag, " wr_addr"}, {59'd0, wr_addr}, 64'd7);
            chk({tag, " wr_data"}, wr_data, 64'hABCD);
        end
    endtask

    task automatic t_cmov();
        cm_case("R7 CMOV EQ true", 7'h24, 64'd0, 1'b1);
        cm_case("R7 CMOV EQ false", 7'h24, 64'd1, 1'b0);
        cm_case("R7 CMOV NE true", 7'h26, 64'd4, 1'b1);
        cm_case("R7 CMOV LT true", 7'h44, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1);
        cm_case("R7 CMOV GE false", 7'h46, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
        cm_case("R7 CMOV LE true", 7'h64, 64'd0, 1'b1);
        cm_case("R7 CMOV GT false", 7'h66, 64'd0, 1'b0);
        cm_case("R7 CMOV GT true", 7'h66, 64'd9, 1'b1);
        cm_case("R7 CMOV LBS true", 7'h14, 64'd1, 1'b1);
        cm_case("R7 CMOV LBC false", 7'h16, 64'd1, 1'b0);
        issue(cmov_word(7'h24, 5'd31, 1'b0, 8'd0), 64'h6000, 64'd0, 64'hABCD);
        chk("R9 CMOV to r31 dropped", {63'd0, wr_en}, 64'd0);
    endtask

    task automatic t_cmov_literal();
        issue(cmov_word(7'h24, 5'd4, 1'b1, 8'hC5), 64'h7000, 64'd0, 64'h1111);
        chk("R8 literal wr_en", {63'd0, wr_en}, 64'd1);
        chk("R8 literal zero-extended", wr_data, 64'hC5);
        chk("R8 literal wr_addr", {59'd0, wr_addr}, 64'd4);
    endtask

    task automatic t_unknown();
        issue(32'h4000_1234, 64'h8000, 64'd0, 64'd0);
        chk("R11 unknown opcode redirect", {63'd0, redirect}, 64'd0);
        chk("R11 unknown opcode write", {63'd0, wr_en}, 64'd0);
        chk("R11 unknown opcode next_pc", next_pc, 64'h8004);
        issue(cmov_word(7'h25, 5'd7, 1'b0, 8'd0), 64'h8100, 64'd0, 64'h55);
        chk("R11 unlisted move function write", {63'd0, wr_en}, 64'd0);
        chk("R11 unlisted move function next_pc", next_pc, 64'h8104);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        instr = br_word(6'h30, 5'd0, 21'd1); pc = 64'h9000; issue_valid = 1'b1;
        @(negedge clk);
        chk("R10 first taken", {63'd0, redirect}, 64'd1);
        chk("R10 first target", next_pc, 64'h9008);
        instr = br_word(6'h39, 5'd0, 21'd2); pc = 64'h9008; ra_val = 64'd0;
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R10 second taken", {63'd0, redirect}, 64'd1);
        chk("R10 second target", next_pc, 64'h9014);
        @(negedge clk);
        chk("R10 idle cycle redirect", {63'd0, redirect}, 64'd0);
        chk("R10 idle cycle wr_en", {63'd0, wr_en}, 64'd0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_signed_branches();
        t_low_bit();
        t_targets();
        t_uncond();
        t_jump();
        t_cmov();
        t_cmov_literal();
        t_unknown();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule